// File: doc/BRIEF.md
# Temperature-Stepped Fan Duty Controller

This block drives a cooling fan with a pulse-width modulated output. Its duty follows a raw 16-bit temperature code, which arrives with a one-cycle valid strobe. The duty does not vary smoothly. It takes one of five steps: none, a quarter, a half, three quarters or all of the PWM period. Each of the four boundaries between steps has its own pair of thresholds. A sample above the upper threshold of a pair moves the fan up. The fan only drops back once a sample goes below the lower threshold of that pair, so a temperature that hovers near one value does not make the duty toggle.

A small register port holds the control bit, the threshold pairs and the pulse-width register, which software may overwrite to force a duty. It also returns the fixed period and the current step. The block raises a one-cycle event each time it picks a higher step by itself. After any duty change, whether chosen by the block or written by software, it waits a programmable settle time for the fan speed to steady and then raises a second one-cycle event. Nothing runs until software sets the run bit.

Top module: `fan_duty_ctrl`

## Requirements
- R1: After rst_n is low at a clock edge, pwm_out, duty_level and both events are 0, the run bit is 0, every upper threshold (addresses 4 to 7) reads 16'hFFFF and every lower threshold (addresses 8 to 11) reads 0.
- R2: While the run bit (address 0, bit 0) is 0, pwm_out stays low one cycle later, duty_level is 0, temperature samples are ignored, and writes to the width register (address 1) are ignored, so it reads 0.
- R3: On a temperature sample, if the code is strictly greater than the upper threshold of some boundary b (1 to 4, upper threshold at address 3+b) with b above the current step, the step becomes the highest such b. The width becomes step*PERIOD/4 (integer division). evt_temp_up is high for exactly the following cycle.
- R4: On a sample that raises nothing, the step drops from L only when the code is below the lower threshold of boundary L (address 7+L). It drops to the highest b below L whose lower threshold is at most the code, or to 0 if there is none. evt_temp_up stays low.
- R5: A sample that is at or above the lower threshold of the current step, and not above the upper threshold of any higher boundary, leaves the step and the width unchanged.
- R6: A counter runs from 0 to PERIOD-1 and wraps. One cycle after each clock edge, pwm_out is high exactly when the counter was below the width. A width of 0 keeps it low and a width of PERIOD keeps it high.
- R7: While running, a write to address 1 sets the width to the written value, clamped to PERIOD. The width then holds until the next step change replaces it.
- R8: Every step change or width write starts a settle wait of SETTLE_CYCLES cycles. evt_pwm_settled is high for the single cycle after the edge that lies SETTLE_CYCLES edges after the change. A new change during the wait restarts it, and the two events are never high together.
- R9: Address 2 reads PERIOD, and writes to it have no effect.
- R10: Address 3 reads the current step (0 to 4). Addresses 0, 1 and 4 to 11 read back what they hold. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| temp_code | input | 16 | Raw temperature code |
| temp_valid | input | 1 | Temperature sample strobe |
| pwm_out | output | 1 | Fan PWM output |
| duty_level | output | 3 | Current duty step 0 to 4 |
| evt_temp_up | output | 1 | Block selected a higher step |
| evt_pwm_settled | output | 1 | Settle wait after a duty change ended |

## Verification
The bench sends temperature codes that cross a single upper threshold, jump over several boundaries at once, and land inside a hysteresis band. These separate stepping up from merely holding, and show whether a drop is blocked by the lower threshold. Downward samples that fall through one band or through all of them show whether the descent lands on the correct step. Software widths above, at and below the period test the clamp and the override. A change issued in the middle of a settle wait shows whether the wait restarts or fires early.

// File: rtl/fanpwm_pkg.sv
// Package: shared constants and types of the fan duty controller.
// Assumes a 4-bit register address space and 16-bit data words.
package fanpwm_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int NB     = 4;               // number of step boundaries
    localparam int LVL_W  = $clog2(NB + 1);  // bits for step 0..NB

    localparam int A_CTRL   = 0;
    localparam int A_WIDTH  = 1;
    localparam int A_PERIOD = 2;
    localparam int A_LEVEL  = 3;
    localparam int A_RISE0  = 4;             // upper thresholds, boundary 1..NB
    localparam int A_FALL0  = A_RISE0 + NB;  // lower thresholds, boundary 1..NB

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LVL_W-1:0]  lvl_t;
endpackage

// File: rtl/fanpwm_regs.sv
// Register bank: holds the run bit and the threshold pairs, decodes width
// writes for the step logic and muxes read data. Assumes PERIOD fits DATA_W.
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int PERIOD = 256,
    localparam int CNT_W = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data,
    input  logic [CNT_W-1:0]  width,
    input  lvl_t              level,
    output logic              run,
    output word_t [NB-1:0]    rise,
    output word_t [NB-1:0]    fall,
    output logic              sw_we,
    output word_t             sw_data
);
    // Run bit: cleared by reset, written at the control address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (wr_en && wr_addr == ADDR_W'(A_CTRL))
            run <= wr_data[0];
    end

    // One upper and one lower threshold register per boundary.
    for (genvar b = 0; b < NB; b++) begin : g_thr
        // Upper threshold: reset high so nothing rises by default.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rise[b] <= '1;
            else if (wr_en && wr_addr == ADDR_W'(A_RISE0 + b))
                rise[b] <= wr_data;
        end
        // Lower threshold: reset low.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fall[b] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(A_FALL0 + b))
                fall[b] <= wr_data;
        end
    end

    // Width writes are handed to the step logic, which owns the width.
    assign sw_we   = wr_en && wr_addr == ADDR_W'(A_WIDTH);
    assign sw_data = wr_data;

    // Read mux over all addresses; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_CTRL))   rd_data = DATA_W'(run);
        if (rd_addr == ADDR_W'(A_WIDTH))  rd_data = DATA_W'(width);
        if (rd_addr == ADDR_W'(A_PERIOD)) rd_data = DATA_W'(PERIOD);
        if (rd_addr == ADDR_W'(A_LEVEL))  rd_data = DATA_W'(level);
        for (int b = 0; b < NB; b++) begin
            if (rd_addr == ADDR_W'(A_RISE0 + b)) rd_data = rise[b];
            if (rd_addr == ADDR_W'(A_FALL0 + b)) rd_data = fall[b];
        end
    end
endmodule

// File: rtl/fanpwm_step.sv
// Step selector: applies the hysteresis rule to each temperature sample,
// owns the width register and flags every duty change. Assumes thresholds
// are compared as unsigned codes.
module fanpwm_step
    import fanpwm_pkg::*;
#(
    parameter int PERIOD = 256,
    localparam int CNT_W = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  word_t            temp_code,
    input  logic             temp_valid,
    input  word_t [NB-1:0]   rise,
    input  word_t [NB-1:0]   fall,
    input  logic             sw_we,
    input  word_t            sw_data,
    output lvl_t             level,
    output logic [CNT_W-1:0] width,
    output logic             evt_up,
    output logic             restart
);
    lvl_t             up_tgt, dn_tgt, nxt_lvl;
    logic             lvl_chg;
    logic [CNT_W-1:0] auto_w, sw_w;

    // Highest boundary whose upper threshold is exceeded.
    always_comb begin
        up_tgt = '0;
        for (int b = 0; b < NB; b++)
            if (temp_code > rise[b]) up_tgt = LVL_W'(b + 1);
    end

    // Highest boundary at or under the current step still held by its lower threshold.
    always_comb begin
        dn_tgt = '0;
        for (int b = 0; b < NB; b++)
            if (LVL_W'(b + 1) <= level && temp_code >= fall[b]) dn_tgt = LVL_W'(b + 1);
    end

    // Next step, its width and the clamped software width.
    always_comb begin
        nxt_lvl = (up_tgt > level) ? up_tgt : dn_tgt;
        lvl_chg = run && temp_valid && nxt_lvl != level;
        auto_w  = CNT_W'((int'(nxt_lvl) * PERIOD) / NB);
        sw_w    = (int'(sw_data) > PERIOD) ? CNT_W'(PERIOD) : CNT_W'(sw_data);
    end

    assign restart = lvl_chg || (run && sw_we);

    // Step, width and rise event registers; held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            level  <= '0;
            width  <= '0;
            evt_up <= 1'b0;
        end else begin
            evt_up <= lvl_chg && nxt_lvl > level;
            if (lvl_chg) begin
                level <= nxt_lvl;
                width <= auto_w;
            end else if (sw_we) begin
                width <= sw_w;
            end
        end
    end
endmodule

// File: rtl/fanpwm_settle.sv
// Settle timer: restarts on each duty change and pulses once when the
// wait has run out. Assumes SETTLE_CYCLES >= 1.
module fanpwm_settle #(
    parameter int SETTLE_CYCLES = 500_000_000,
    localparam int SW = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic evt_done
);
    logic [SW-1:0] cnt;
    logic          busy;

    // Countdown with restart; fires on the edge where one cycle was left.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt      <= '0;
            busy     <= 1'b0;
            evt_done <= 1'b0;
        end else if (restart) begin
            cnt      <= SW'(SETTLE_CYCLES);
            busy     <= 1'b1;
            evt_done <= 1'b0;
        end else begin
            evt_done <= busy && cnt == SW'(1);
            if (busy) begin
                cnt <= cnt - SW'(1);
                if (cnt == SW'(1)) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fanpwm_gen.sv
// PWM generator: free-running counter over the period, registered
// compare against the width. Assumes PERIOD >= 1.
module fanpwm_gen #(
    parameter int PERIOD = 256,
    localparam int CNT_W = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] width,
    output logic             pwm
);
    logic [CNT_W-1:0] ctr;

    // Counter wrap and output compare; both held low while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ctr <= '0;
            pwm <= 1'b0;
        end else begin
            pwm <= ctr < width;
            ctr <= (ctr == CNT_W'(PERIOD - 1)) ? '0 : ctr + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fan_duty_ctrl.sv
// Top: temperature-stepped fan duty controller. Wires the register bank,
// step selector, settle timer and PWM generator. Assumes temp_valid is a
// single-cycle strobe synchronous to clk.
module fan_duty_ctrl
    import fanpwm_pkg::*;
#(
    parameter int PERIOD        = 256,
    parameter int SETTLE_CYCLES = 500_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [15:0] rd_data,
    input  logic [15:0] temp_code,
    input  logic        temp_valid,
    output logic        pwm_out,
    output logic [2:0]  duty_level,
    output logic        evt_temp_up,
    output logic        evt_pwm_settled
);
    localparam int CNT_W = $clog2(PERIOD + 1);

    logic             run_q, sw_we, restart;
    word_t            sw_data;
    word_t [NB-1:0]   rise, fall;
    lvl_t             level_q;
    logic [CNT_W-1:0] width_q;

    fanpwm_regs #(.PERIOD(PERIOD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .width(width_q), .level(level_q), .run(run_q), .rise(rise),
        .fall(fall), .sw_we(sw_we), .sw_data(sw_data)
    );

    fanpwm_step #(.PERIOD(PERIOD)) u_step (
        .clk(clk), .rst_n(rst_n), .run(run_q), .temp_code(temp_code),
        .temp_valid(temp_valid), .rise(rise), .fall(fall), .sw_we(sw_we),
        .sw_data(sw_data), .level(level_q), .width(width_q),
        .evt_up(evt_temp_up), .restart(restart)
    );

    fanpwm_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .run(run_q), .restart(restart),
        .evt_done(evt_pwm_settled)
    );

    fanpwm_gen #(.PERIOD(PERIOD)) u_gen (
        .clk(clk), .rst_n(rst_n), .run(run_q), .width(width_q), .pwm(pwm_out)
    );

    assign duty_level = 3'(level_q);
endmodule

// File: rtl/fan_duty_ctrl_chk.sv
// Checker: temporal properties of the fan duty controller, bound to the top.
module fan_duty_ctrl_chk #(
    parameter int PERIOD = 256,
    parameter int CNT_W  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [CNT_W-1:0] width,
    input logic             pwm_out,
    input logic [2:0]       duty_level,
    input logic             evt_temp_up,
    input logic             evt_pwm_settled
);
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        duty_level <= 3'd4);

    assert_up_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_temp_up |-> duty_level > $past(duty_level));

    assert_no_up_on_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_level < $past(duty_level)) |-> !evt_temp_up);

    assert_stopped_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pwm_out);

    assert_zero_width_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && width == '0) |=> !pwm_out);

    assert_full_width_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && int'(width) == PERIOD) |=> pwm_out);

    assert_width_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(width) <= PERIOD);

    assert_events_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_temp_up && evt_pwm_settled));
endmodule

bind fan_duty_ctrl fan_duty_ctrl_chk #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .width(width_q), .pwm_out(pwm_out),
    .duty_level(duty_level), .evt_temp_up(evt_temp_up),
    .evt_pwm_settled(evt_pwm_settled)
);

// File: tb/sim_fan_duty_ctrl.sv
module sim_fan_duty_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 20;
    localparam int SETTLE     = 20;
    localparam int WDOG       = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] temp_code = '0;
    logic        temp_valid = 1'b0;
    logic        pwm_out, evt_temp_up, evt_pwm_settled;
    logic [2:0]  duty_level;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    fan_duty_ctrl #(.PERIOD(PER), .SETTLE_CYCLES(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .temp_code(temp_code), .temp_valid(temp_valid), .pwm_out(pwm_out),
        .duty_level(duty_level), .evt_temp_up(evt_temp_up),
        .evt_pwm_settled(evt_pwm_settled)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state, built from the requirements.
    int m_run, m_lvl, m_w, m_ctr, m_pwm, m_up, m_set, m_busy, m_cnt;
    int m_rise[4], m_fall[4];

    function automatic int m_read(int a);
        if (a == 0) return m_run;
        if (a == 1) return m_w;
        if (a == 2) return PER;
        if (a == 3) return m_lvl;
        if (a >= 4 && a <= 7) return m_rise[a-4];
        if (a >= 8 && a <= 11) return m_fall[a-8];
        return 0;
    endfunction

    // Model update at each edge from the pre-edge state and inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_lvl = 0; m_w = 0; m_ctr = 0; m_pwm = 0;
            m_up = 0; m_set = 0; m_busy = 0; m_cnt = 0;
            for (int b = 0; b < 4; b++) begin m_rise[b] = 65535; m_fall[b] = 0; end
        end else begin
            int up, dn, nl, chg, sww, orun, t;
            orun = m_run; t = temp_code;
            if (orun == 0) begin
                m_lvl = 0; m_w = 0; m_ctr = 0; m_pwm = 0;
                m_up = 0; m_set = 0; m_busy = 0; m_cnt = 0;
            end else begin
                up = 0; dn = 0;
                for (int b = 1; b <= 4; b++) begin
                    if (t > m_rise[b-1]) up = b;
                    if (b <= m_lvl && t >= m_fall[b-1]) dn = b;
                end
                nl  = (up > m_lvl) ? up : dn;
                chg = temp_valid && nl != m_lvl;
                sww = wr_en && wr_addr == 4'd1;
                m_pwm = (m_ctr < m_w) ? 1 : 0;
                m_ctr = (m_ctr == PER-1) ? 0 : m_ctr + 1;
                m_up  = (chg && nl > m_lvl) ? 1 : 0;
                if (chg || sww) begin
                    m_busy = 1; m_cnt = SETTLE; m_set = 0;
                end else begin
                    m_set = (m_busy && m_cnt == 1) ? 1 : 0;
                    if (m_busy) begin
                        if (m_cnt == 1) m_busy = 0;
                        m_cnt--;
                    end
                end
                if (chg) begin
                    m_lvl = nl; m_w = nl * PER / 4;
                end else if (sww) begin
                    m_w = (int'(wr_data) > PER) ? PER : int'(wr_data);
                end
            end
            if (wr_en) begin
                if (wr_addr == 4'd0) m_run = int'(wr_data[0]);
                if (wr_addr >= 4 && wr_addr <= 7) m_rise[wr_addr-4] = wr_data;
                if (wr_addr >= 8 && wr_addr <= 11) m_fall[wr_addr-8] = wr_data;
            end
        end
    end

    task automatic chk(int act, int exp, string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(int'(pwm_out), m_pwm, "R6 pwm_out");
            chk(int'(duty_level), m_lvl, "R3/R4/R5 duty_level");
            chk(int'(evt_temp_up), m_up, "R3 evt_temp_up");
            chk(int'(evt_pwm_settled), m_set, "R8 evt_pwm_settled");
            chk(int'(rd_data), m_read(int'(rd_addr)), "R10 rd_data");
        end
        if (cyc > WDOG && !done) begin
            done = 1; n_fail++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic tsamp(int v);
        @(posedge clk); #1;
        temp_valid = 1; temp_code = 16'(v);
        @(posedge clk); #1;
        temp_valid = 0;
    endtask

    task automatic rd(int a, int exp, string req);
        @(posedge clk); #1;
        rd_addr = 4'(a);
        @(negedge clk);
        chk(int'(rd_data), exp, req);
    endtask

    initial begin
        int hit;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(int'(pwm_out), 0, "R1 pwm after reset");
        chk(int'(duty_level), 0, "R1 level after reset");
        rd(0, 0, "R1 run bit");
        rd(4, 65535, "R1 upper threshold");
        rd(11, 0, "R1 lower threshold");

        for (int b = 0; b < 4; b++) begin
            wr(4 + b, 100 * (b + 1));
            wr(8 + b, 100 * (b + 1) - 20);
        end
        rd(6, 300, "R10 upper threshold 3");
        rd(9, 180, "R10 lower threshold 2");

        // Stopped: samples and width writes ignored.
        tsamp(1000);
        @(negedge clk);
        chk(int'(duty_level), 0, "R2 sample ignored while stopped");
        wr(1, 10);
        rd(1, 0, "R2 width write ignored while stopped");
        repeat (5) @(negedge clk);
        chk(int'(pwm_out), 0, "R2 pwm low while stopped");

        wr(0, 1);
        rd(0, 1, "R10 run bit");
        tsamp(150);
        @(negedge clk);
        chk(int'(evt_temp_up), 1, "R3 rise event");
        chk(int'(duty_level), 1, "R3 step 1");
        hit = 0;
        for (int k = 2; k <= SETTLE + 5; k++) begin
            @(negedge clk);
            if (evt_pwm_settled && hit == 0) hit = k;
        end
        chk(hit, SETTLE + 1, "R8 settle pulse cycle");
        rd(1, 5, "R3 width for step 1");
        repeat (2 * PER) @(posedge clk);

        tsamp(350);
        @(negedge clk);
        chk(int'(duty_level), 3, "R3 jump to step 3");
        repeat (SETTLE + 5) @(posedge clk);
        tsamp(290);
        @(negedge clk);
        chk(int'(duty_level), 3, "R5 held in band");
        chk(int'(evt_temp_up), 0, "R5 no event in band");
        tsamp(250);
        @(negedge clk);
        chk(int'(duty_level), 2, "R4 drop to step 2");
        chk(int'(evt_temp_up), 0, "R4 no rise event on drop");
        repeat (2 * PER) @(posedge clk);
        tsamp(50);
        @(negedge clk);
        chk(int'(duty_level), 0, "R4 drop through all bands");
        repeat (PER) @(posedge clk);

        // Full duty, then restart the settle wait midway.
        tsamp(500);
        repeat (SETTLE / 2) @(posedge clk);
        tsamp(150);
        @(negedge clk);
        chk(int'(duty_level), 1, "R4 drop from step 4");
        repeat (SETTLE + 5) @(posedge clk);
        tsamp(500);
        repeat (3 * PER) @(posedge clk);

        wr(1, 30);
        rd(1, PER, "R7 width clamped");
        wr(1, 7);
        rd(1, 7, "R7 width override");
        repeat (2 * PER + SETTLE) @(posedge clk);
        wr(1, 0);
        repeat (PER) @(posedge clk);
        wr(1, PER);
        repeat (PER) @(posedge clk);

        wr(2, 99);
        rd(2, PER, "R9 period read-only");
        rd(12, 0, "R10 unmapped address");

        wr(0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(int'(pwm_out), 0, "R2 pwm low after stop");
        chk(int'(duty_level), 0, "R2 level cleared on stop");
        repeat (3) @(posedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule